// File: doc/BRIEF.md
# HDLC Bit-Destuffing Frame Receiver

This block takes a serial bit-stuffed HDLC line and turns it into bytes. It takes one line bit on each clock where the receive enable is high. Clocks where the enable is low are stalls, so several receivers can share a time-multiplexed highway. The block looks for the opening flag and then removes the zeros that the sender stuffed into the stream. It packs the remaining bits into bytes, least significant bit first, and runs a 16-bit frame check sequence over them.

Each payload byte comes out on a byte-wide output with a one-clock strobe. The two check bytes at the tail of a frame are never delivered. A three-byte holding queue lets the block mark the real last payload byte as final, on the same strobe that carries it. The frame-error flag shares that strobe when the check fails or the closing flag is misaligned. Between frames the line may carry continuous ones or back-to-back flags. Neither kind of fill produces output.

Top module: `hdlc_destuff_rx`

## Requirements
- R1: On a sampled tick, a zero that follows exactly five consecutive ones inside a frame is dropped and does not count as a data bit.
- R2: Payload bits are packed least significant bit first. Each payload byte other than the last is presented on `byte_out`, with `byte_stb` high for exactly one clock and `frame_end` low.
- R3: For a frame with at least one payload byte, the last payload byte is presented with `byte_stb` and `frame_end` both high in the same clock. The two check bytes are never presented.
- R4: `frame_err` is high together with `frame_end` when the CRC-16 (reflected polynomial 0x8408, preset 0xFFFF) over payload plus check bytes does not leave the residue 0xF0B8. It is also high when the closing flag does not follow a whole number of destuffed bytes. Otherwise it is low.
- R5: A flag is the bit sequence 0, six ones, 0. Continuous ones, back-to-back flags, and frames with fewer than three bytes between flags all produce no strobe.
- R6: Seven or more consecutive ones abort the frame in progress. Its end is never marked.
- R7: Clocks with `rx_en` low do not sample `rx_bit`, do not advance any state, and produce no strobe in the following clock.
- R8: After reset, `byte_stb`, `frame_end`, `frame_err` and `byte_out` are all zero.
- R9: The frame length has no upper limit. A 40-byte payload is delivered in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Tick enable; the line bit is taken only when high |
| rx_bit | input | 1 | Serial line data |
| byte_out | output | 8 | Received payload byte |
| byte_stb | output | 1 | One-clock strobe marking a valid `byte_out` |
| frame_end | output | 1 | Marks the last payload byte of a frame |
| frame_err | output | 1 | Check or alignment failure for the frame being ended |

## Verification
All outputs are registered, so each result appears one clock after the enabled tick that causes it. A payload byte is strobed one clock after the tick that completes the third byte after it. The final byte, with its end and error flags, appears one clock after the tick carrying the closing flag's last zero. The bench drives and samples on the falling edge and logs every strobe as it arrives. It lets several idle clocks pass after each closing flag before it compares the log with the frame it built itself.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;
  localparam logic [15:0] FCS_POLY = 16'h8408;
  localparam logic [15:0] FCS_INIT = 16'hFFFF;
  localparam logic [15:0] FCS_GOOD = 16'hF0B8;

  // Fold one byte, least significant bit first, into the running check value.
  function automatic logic [15:0] fcs_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ FCS_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction
endpackage

// File: rtl/hdlc_rx_linemon.sv
module hdlc_rx_linemon #(
  parameter int FLAG_RUN  = 6,
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_bit,
  output logic ev_flag,
  output logic ev_abort,
  output logic ev_stuff,
  output logic ev_data
);
  localparam int CW  = $clog2(FLAG_RUN + 2);
  localparam int SAT = FLAG_RUN + 1;

  logic [CW-1:0] ones;

  always_ff @(posedge clk) begin
    if (!rst_n)            ones <= '0;
    else if (tick) begin
      if (!line_bit)       ones <= '0;
      else if (ones != CW'(SAT)) ones <= ones + 1'b1;
    end
  end

  assign ev_flag  = tick & ~line_bit & (ones == CW'(FLAG_RUN));
  assign ev_abort = tick &  line_bit & (ones >= CW'(FLAG_RUN));
  assign ev_stuff = tick & ~line_bit & (ones == CW'(STUFF_RUN));
  assign ev_data  = tick & ~ev_flag & ~ev_abort & ~ev_stuff;
endmodule

// File: rtl/hdlc_rx_bytepack.sv
module hdlc_rx_bytepack #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_bit,
  input  logic              ev_flag,
  input  logic              ev_abort,
  input  logic              ev_data,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              close_evt,
  output logic              aligned
);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] LAST = BW'(BYTE_W - 1);

  logic              in_frame;
  logic [BW-1:0]     bitcnt;
  logic [BYTE_W-1:0] sr;

  assign byte_val  = {line_bit, sr[BYTE_W-1:1]};
  assign byte_done = ev_data & in_frame & (bitcnt == LAST);
  assign close_evt = ev_flag & in_frame;
  assign aligned   = (bitcnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      bitcnt   <= '0;
      sr       <= '0;
    end else if (ev_flag) begin
      in_frame <= 1'b1;
      bitcnt   <= '0;
    end else if (ev_abort) begin
      in_frame <= 1'b0;
      bitcnt   <= '0;
    end else if (ev_data && in_frame) begin
      sr     <= byte_val;
      bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + 1'b1;
    end
  end
endmodule

// File: rtl/hdlc_rx_tail.sv
module hdlc_rx_tail
  import hdlc_rx_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int FCS_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              close_evt,
  input  logic              aligned,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              frame_end,
  output logic              frame_err,
  output logic              fcs_ok
);
  localparam int DEPTH = FCS_BYTES + 1;
  localparam int CNTW  = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] q [DEPTH];
  logic [CNTW-1:0]   fill;
  logic [15:0]       crc;
  logic              full;

  assign full   = (fill == CNTW'(DEPTH));
  assign fcs_ok = (crc == FCS_GOOD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
      fill      <= '0;
      crc       <= FCS_INIT;
      byte_out  <= '0;
      byte_stb  <= 1'b0;
      frame_end <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      byte_stb  <= 1'b0;
      frame_end <= 1'b0;
      frame_err <= 1'b0;
      if (restart) begin
        if (close_evt && full) begin
          byte_out  <= q[DEPTH-1];
          byte_stb  <= 1'b1;
          frame_end <= 1'b1;
          frame_err <= ~fcs_ok | ~aligned;
        end
        fill <= '0;
        crc  <= FCS_INIT;
      end else if (byte_done) begin
        crc  <= fcs_step(crc, byte_val);
        q[0] <= byte_val;
        for (int i = 1; i < DEPTH; i++) q[i] <= q[i-1];
        if (full) begin
          byte_out <= q[DEPTH-1];
          byte_stb <= 1'b1;
        end else begin
          fill <= fill + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hdlc_destuff_rx.sv
module hdlc_destuff_rx #(
  parameter int BYTE_W    = 8,
  parameter int FLAG_RUN  = 6,
  parameter int STUFF_RUN = 5,
  parameter int FCS_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_bit,
  output logic [BYTE_W-1:0] byte_out,
  output logic              byte_stb,
  output logic              frame_end,
  output logic              frame_err
);
  logic              ev_flag, ev_abort, ev_stuff, ev_data;
  logic              byte_done, close_evt, aligned, fcs_ok;
  logic [BYTE_W-1:0] byte_val;

  hdlc_rx_linemon #(.FLAG_RUN(FLAG_RUN), .STUFF_RUN(STUFF_RUN)) u_mon (
    .clk(clk), .rst_n(rst_n), .tick(rx_en), .line_bit(rx_bit),
    .ev_flag(ev_flag), .ev_abort(ev_abort), .ev_stuff(ev_stuff), .ev_data(ev_data)
  );

  hdlc_rx_bytepack #(.BYTE_W(BYTE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .line_bit(rx_bit),
    .ev_flag(ev_flag), .ev_abort(ev_abort), .ev_data(ev_data),
    .byte_done(byte_done), .byte_val(byte_val),
    .close_evt(close_evt), .aligned(aligned)
  );

  hdlc_rx_tail #(.BYTE_W(BYTE_W), .FCS_BYTES(FCS_BYTES)) u_tail (
    .clk(clk), .rst_n(rst_n), .restart(ev_flag | ev_abort),
    .close_evt(close_evt), .aligned(aligned),
    .byte_done(byte_done), .byte_val(byte_val),
    .byte_out(byte_out), .byte_stb(byte_stb),
    .frame_end(frame_end), .frame_err(frame_err), .fcs_ok(fcs_ok)
  );
endmodule

// File: rtl/hdlc_destuff_rx_chk.sv
module hdlc_destuff_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic byte_stb,
  input logic frame_end,
  input logic frame_err,
  input logic ev_abort,
  input logic ev_stuff
);
  p_end_has_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> byte_stb);

  p_err_has_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> frame_end);

  p_stall_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !byte_stb);

  p_abort_no_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !frame_end);

  p_stuff_no_stb_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stuff |=> !byte_stb);

  p_single_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);
endmodule

bind hdlc_destuff_rx hdlc_destuff_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .byte_stb(byte_stb),
  .frame_end(frame_end), .frame_err(frame_err),
  .ev_abort(ev_abort), .ev_stuff(ev_stuff)
);

// File: tb/test_hdlc_destuff_rx.sv
module test_hdlc_destuff_rx;
  logic       clk = 1'b0;
  logic       rst_n, rx_en, rx_bit;
  logic [7:0] byte_out;
  logic       byte_stb, frame_end, frame_err;

  always #2.5 clk = ~clk;

  hdlc_destuff_rx i_hdlc_destuff_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
    .byte_out(byte_out), .byte_stb(byte_stb),
    .frame_end(frame_end), .frame_err(frame_err)
  );

  // {len[23:16], seed[15:8], 4'b0, corrupt[3], idle_fill[2], gap[1:0]}
  localparam logic [23:0] VECS [8] = '{
    24'h013C00, 24'h04FF04, 24'h05A50A, 24'h001100,
    24'h287E05, 24'h03FE0F, 24'h020000, 24'h06F804
  };

  int n_chk = 0, n_fail = 0, n_got = 0, n_end = 0, st_ones = 0;
  bit done = 0;
  logic [7:0] got_d [64];
  logic       got_e [64];
  logic       got_x [64];

  always @(negedge clk) begin
    if (rst_n && byte_stb) begin
      if (n_got < 64) begin
        got_d[n_got] = byte_out;
        got_e[n_got] = frame_end;
        got_x[n_got] = frame_err;
      end
      n_got++;
      if (frame_end) n_end++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input logic b, input int gap);
    rx_en = 1'b1; rx_bit = b;
    @(negedge clk);
    for (int g = 0; g < gap; g++) begin
      rx_en = 1'b0; rx_bit = ~b;
      @(negedge clk);
    end
  endtask

  task automatic send_flag(input int gap);
    for (int i = 0; i < 8; i++) tick((i != 0 && i != 7), gap);
    st_ones = 0;
  endtask

  task automatic send_byte(input logic [7:0] d, input int gap);
    for (int i = 0; i < 8; i++) begin
      tick(d[i], gap);
      st_ones = d[i] ? st_ones + 1 : 0;
      if (st_ones == 5) begin tick(1'b0, gap); st_ones = 0; end
    end
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) tick(1'b1, 0);
  endtask

  task automatic settle_clear();
    rx_en = 1'b0;
    repeat (4) @(negedge clk);
    n_got = 0; n_end = 0;
  endtask

  task automatic settle();
    rx_en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // Bench-side check value: byte is XORed in first, then eight shift steps.
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {8'h00, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'h8408) : (r >> 1);
    return r;
  endfunction

  task automatic fill(input bit idle);
    if (idle) send_ones(12);
    else begin send_flag(0); send_flag(0); end
  endtask

  task automatic run_frame(input int len, input logic [7:0] seed, input bit bad,
                           input bit idle, input int gap);
    logic [7:0]  fr [64];
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      fr[i] = seed ^ 8'(i * 17);
      c = ref_crc(c, fr[i]);
    end
    c = ~c;
    if (bad && len > 0) fr[0] = fr[0] ^ 8'h01;
    settle_clear();
    fill(idle);
    send_flag(gap);
    for (int i = 0; i < len; i++) send_byte(fr[i], gap);
    send_byte(c[7:0], gap);
    send_byte(c[15:8], gap);
    send_flag(gap);
    fill(idle);
    settle();
    chk(n_got == len, "R3 R5 R9 byte count", n_got, len);
    for (int i = 0; i < len && i < 64; i++) begin
      chk(got_d[i] == fr[i], "R1 R2 R7 data", got_d[i], fr[i]);
      chk(got_e[i] == (i == len - 1), "R2 R3 end marker", got_e[i], (i == len - 1));
      if (i == len - 1) chk(got_x[i] == bad, "R4 check result", got_x[i], bad);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b0; rx_bit = 1'b1;
    repeat (4) @(negedge clk);
    // R8: reset state
    chk({byte_out, byte_stb, frame_end, frame_err} == 11'h0, "R8 reset outputs",
        {byte_out, byte_stb, frame_end, frame_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Vector table
    for (int v = 0; v < 8; v++) begin
      run_frame(int'(VECS[v][23:16]), VECS[v][15:8], VECS[v][3], VECS[v][2],
                int'(VECS[v][1:0]));
    end

    // R5: fill only, both kinds
    settle_clear();
    send_ones(30);
    for (int i = 0; i < 6; i++) send_flag(0);
    send_ones(20);
    settle();
    chk(n_got == 0, "R5 fill produces nothing", n_got, 0);

    // R6: abort after five bytes
    settle_clear();
    send_flag(0);
    for (int i = 0; i < 5; i++) send_byte(8'h30 + 8'(i), 0);
    send_ones(9);
    settle();
    chk(n_end == 0, "R6 aborted frame not ended", n_end, 0);

    // R4: closing flag off a byte boundary, check bytes correct
    settle_clear();
    send_flag(0);
    begin
      logic [15:0] c;
      c = ~ref_crc(16'hFFFF, 8'h5A);
      send_byte(8'h5A, 0);
      send_byte(c[7:0], 0);
      send_byte(c[15:8], 0);
    end
    tick(1'b0, 0); tick(1'b0, 0); tick(1'b0, 0);
    send_flag(0);
    send_ones(10);
    settle();
    chk(n_end == 1, "R4 misaligned end count", n_end, 1);
    if (n_got > 0 && n_got <= 64)
      chk(got_e[n_got-1] && got_x[n_got-1], "R4 misaligned error",
          {got_e[n_got-1], got_x[n_got-1]}, 2'b11);

    // R7: a full frame pattern on rx_bit with rx_en held low
    settle_clear();
    for (int i = 0; i < 120; i++) begin
      rx_en = 1'b0; rx_bit = (i % 9 == 0) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    settle();
    chk(n_got == 0, "R7 stalled line ignored", n_got, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule